// File: doc/BRIEF.md
# Exponent-Scaled Vector Multiplier

This block multiplies a vector of IEEE single-precision numbers by e raised to a scalar x, where x is expected to be zero or negative, as happens when a running maximum is subtracted from attention scores. It holds neither an exponential unit nor any floating-point multiplier. The scalar is first turned into an unsigned fixed-point magnitude. That magnitude is multiplied by about log2(e) using two shifts, an add and a subtract, and the result is rounded to an integer k. Every vector lane is then multiplied by 2^-k by lowering its biased exponent field by k.

The unit has two pipeline stages and accepts one scalar/vector pair on every clock. The first stage works out k. The second stage adjusts each lane. Results too small to represent as normal numbers become a zero of the same sign rather than a subnormal, so very small tail values are clipped. A consumer pairs each output vector with the input that produced it only by counting cycles; the valid flag travels with the data.

Top module: `expmul_vec`

## Requirements
- R1: When in_valid is high at a rising edge, out_valid is high after the next rising edge, and out_vec holds that input's result. A new pair can be taken on every edge, and out_valid is low otherwise.
- R2: A negative scalar becomes a magnitude m with 8 fraction bits: m = floor(|x|*256), clipped at 65535. A zero or subnormal scalar gives m = 0. Negative infinity or NaN with the sign bit set gives m = 65535.
- R3: k = floor((y + 128) / 256), where y = m + floor(m/2) - floor(m/16). Values of k above 255 are clipped to 255.
- R4: A scalar with its sign bit clear (positive, +0, +inf or a NaN with the sign clear) gives k = 0.
- R5: A lane with biased exponent field E (bits 30:23) that is not 255, where E > k, leaves with exponent E - k. Its sign (bit 31) and mantissa (bits 22:0) are unchanged.
- R6: When k >= 1, a lane with 255 > E and E <= k leaves as a zero that keeps its sign bit. This covers zeros and subnormals.
- R7: A lane whose exponent field is 255 (infinity or NaN) passes through bit for bit.
- R8: When k = 0, every lane passes through bit for bit, subnormals included.
- R9: While rst_n is low, and for the first edge after it is released, out_valid is low.
- Lane i occupies bits 32*i+31 down to 32*i of in_vec and out_vec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| in_valid | input | 1 | Marks in_x and in_vec as a pair to process |
| in_x | input | 32 | Scalar exponent argument, IEEE single |
| in_vec | input | 32*LANES | Vector to scale, one IEEE single per lane |
| out_valid | output | 1 | Marks out_vec as a result |
| out_vec | output | 32*LANES | Scaled vector |

## Verification
The scalar is tried with whole numbers, fractions, tiny values, subnormals, signed zeros, infinity, values large enough to clip k, and positive values. Together these separate errors in the float-to-fixed conversion, in the truncating shift terms, in the rounding and in the clip at 255. The lanes carry normal values with exponents just above and just at k, along with zeros, subnormals, infinities and NaNs, so the subtraction, the zero-clipping boundary and the pass-through classes each show up at the outputs. Back-to-back pairs with idle gaps between runs check that valid and data stay aligned.

// File: rtl/expmul_pkg.sv
package expmul_pkg;

   localparam int SP_W    = 32;
   localparam int SP_EW   = 8;
   localparam int SP_MW   = 23;
   localparam int SP_BIAS = 127;

   typedef struct packed {
      logic             sgn;
      logic [SP_EW-1:0] ex;
      logic [SP_MW-1:0] man;
   } sp_t;

   localparam logic [SP_EW-1:0] EX_SPECIAL = '1;

endpackage

// File: rtl/expmul_scalar_q.sv
module expmul_scalar_q
   import expmul_pkg::*;
#(
   parameter int INT_W         = 8,
   parameter int FRAC_W        = 8,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SP_W-1:0]  x_i,
   output logic [SP_EW-1:0] k_o
);

   localparam int FX_W   = INT_W + FRAC_W;
   localparam int MANT_W = SP_MW + 1;
   localparam int WIDE_W = FX_W + MANT_W;
   localparam int Y_W    = FX_W + 1;
   localparam int R_W    = FX_W + 2;
   localparam logic [R_W-1:0] K_MAX = R_W'((1 << SP_EW) - 1);

   if (FRAC_W < 4) begin : g_chk_frac
      $error("expmul_scalar_q: FRAC_W must be at least 4");
   end
   if (INT_W < 1) begin : g_chk_int
      $error("expmul_scalar_q: INT_W must be at least 1");
   end
   if (R_W <= SP_EW) begin : g_chk_range
      $error("expmul_scalar_q: fixed-point width too small for k");
   end

   sp_t               xs;
   logic [FX_W-1:0]   mag;
   logic [WIDE_W-1:0] wide;
   logic              sat;
   int                shamt;
   logic [Y_W-1:0]    y;
   logic [R_W-1:0]    r;
   logic [R_W-1:0]    q;
   logic [SP_EW-1:0]  k_d;

   assign xs = sp_t'(x_i);

   // float -> unsigned fixed magnitude, truncating, saturating
   always_comb begin
      sat   = 1'b0;
      mag   = '0;
      wide  = '0;
      shamt = int'(xs.ex) - (SP_BIAS + SP_MW) + FRAC_W;
      if (!xs.sgn) begin
         mag = '0;
      end else if (xs.ex == EX_SPECIAL) begin
         sat = 1'b1;
      end else if (xs.ex == '0) begin
         mag = '0;
      end else if (shamt >= 0) begin
         if (shamt > FX_W) begin
            sat = 1'b1;
         end else begin
            wide = {{FX_W{1'b0}}, 1'b1, xs.man} << shamt;
            if (|wide[WIDE_W-1:FX_W]) sat = 1'b1;
            else                      mag = wide[FX_W-1:0];
         end
      end else if (-shamt < MANT_W) begin
         wide = {{FX_W{1'b0}}, 1'b1, xs.man} >> (-shamt);
         if (|wide[WIDE_W-1:FX_W]) sat = 1'b1;
         else                      mag = wide[FX_W-1:0];
      end
      if (sat) mag = '1;
   end

   // m * log2(e) ~ m + m/2 - m/16
   assign y = Y_W'(mag) + Y_W'(mag >> 1) - Y_W'(mag >> 4);

   if (ROUND_NEAREST) begin : g_round_near
      localparam logic [R_W-1:0] HALF = R_W'(1) << (FRAC_W - 1);
      assign r = {1'b0, y} + HALF;
   end else begin : g_round_trunc
      assign r = {1'b0, y};
   end

   assign q   = r >> FRAC_W;
   assign k_d = (q > K_MAX) ? K_MAX[SP_EW-1:0] : q[SP_EW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) k_o <= '0;
      else        k_o <= k_d;
   end

endmodule

// File: rtl/expmul_lane.sv
module expmul_lane
   import expmul_pkg::*;
(
   input  logic [SP_EW-1:0] k_i,
   input  logic [SP_W-1:0]  d_i,
   output logic [SP_W-1:0]  d_o
);

   sp_t din;
   sp_t dout;

   assign din = sp_t'(d_i);

   always_comb begin
      dout = din;
      if (k_i == '0 || din.ex == EX_SPECIAL) begin
         dout = din;
      end else if (din.ex <= k_i) begin
         dout.sgn = din.sgn;
         dout.ex  = '0;
         dout.man = '0;
      end else begin
         dout.ex = din.ex - k_i;
      end
   end

   assign d_o = dout;

endmodule

// File: rtl/expmul_vec.sv
module expmul_vec
   import expmul_pkg::*;
#(
   parameter int LANES         = 4,
   parameter int INT_W         = 8,
   parameter int FRAC_W        = 8,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [SP_W-1:0]       in_x,
   input  logic [LANES*SP_W-1:0] in_vec,
   output logic                  out_valid,
   output logic [LANES*SP_W-1:0] out_vec
);

   localparam int VEC_W = LANES * SP_W;

   if (LANES < 1) begin : g_chk_lanes
      $error("expmul_vec: LANES must be at least 1");
   end

   logic [SP_EW-1:0] s1_k;
   logic             s1_valid;
   logic [VEC_W-1:0] s1_vec;
   logic [VEC_W-1:0] lane_res;

   expmul_scalar_q #(
      .INT_W         (INT_W),
      .FRAC_W        (FRAC_W),
      .ROUND_NEAREST (ROUND_NEAREST)
   ) u_scalar (
      .clk   (clk),
      .rst_n (rst_n),
      .x_i   (in_x),
      .k_o   (s1_k)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_vec   <= '0;
      end else begin
         s1_valid <= in_valid;
         s1_vec   <= in_vec;
      end
   end

   for (genvar li = 0; li < LANES; li++) begin : g_lane
      expmul_lane u_lane (
         .k_i (s1_k),
         .d_i (s1_vec[li*SP_W +: SP_W]),
         .d_o (lane_res[li*SP_W +: SP_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_vec   <= '0;
      end else begin
         out_valid <= s1_valid;
         out_vec   <= lane_res;
      end
   end

endmodule

// File: rtl/expmul_vec_chk.sv
module expmul_vec_chk
   import expmul_pkg::*;
#(
   parameter int LANES = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic [SP_W-1:0]       in_x,
   input logic [LANES*SP_W-1:0] in_vec,
   input logic                  out_valid,
   input logic [LANES*SP_W-1:0] out_vec
);

   logic [1:0] age;
   logic       warm;

   always_ff @(posedge clk) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   assign warm = (age >= 2'd2);

   assert_quiet_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !warm |-> !out_valid);

   assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (out_valid == $past(in_valid, 2)));

   for (genvar li = 0; li < LANES; li++) begin : g_lane_chk
      assert_special_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (warm && out_valid && $past(in_vec[li*SP_W+30 -: SP_EW], 2) == EX_SPECIAL)
         |-> (out_vec[li*SP_W +: SP_W] == $past(in_vec[li*SP_W +: SP_W], 2)));

      assert_positive_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (warm && out_valid && !$past(in_x[SP_W-1], 2))
         |-> (out_vec[li*SP_W +: SP_W] == $past(in_vec[li*SP_W +: SP_W], 2)));

      assert_sign_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (warm && out_valid)
         |-> (out_vec[li*SP_W+31] == $past(in_vec[li*SP_W+31], 2)));

      assert_no_growth_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (warm && out_valid)
         |-> (out_vec[li*SP_W+30 -: SP_EW] <= $past(in_vec[li*SP_W+30 -: SP_EW], 2)));
   end

endmodule

bind expmul_vec expmul_vec_chk #(.LANES(LANES)) u_expmul_vec_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_x      (in_x),
   .in_vec    (in_vec),
   .out_valid (out_valid),
   .out_vec   (out_vec)
);

// File: tb/expmul_vec_test.sv
`timescale 1ns/1ps
module expmul_vec_test;

   localparam int LANES = 4;
   localparam int VW    = LANES * 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [31:0]   in_x = '0;
   logic [VW-1:0] in_vec = '0;
   logic          out_valid;
   logic [VW-1:0] out_vec;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [VW-1:0] exp_q[$];
   string         tag_q[$];
   int            iss_q[$];

   always #2 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   expmul_vec #(.LANES(LANES)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_x      (in_x),
      .in_vec    (in_vec),
      .out_valid (out_valid),
      .out_vec   (out_vec)
   );

   function automatic logic [31:0] to_sp(real r);
      logic [63:0] b;
      int          e;
      if (r == 0.0) return 32'h0;
      b = $realtobits(r);
      e = int'(b[62:52]) - 1023 + 127;
      return {b[63], 8'(e), b[51:29]};
   endfunction

   // R2, R3, R4: expected k from the requirement text
   function automatic int model_k(logic [31:0] x);
      int  m;
      int  y;
      int  k;
      real rm;
      if (!x[31]) return 0;
      if (x[30:23] == 8'hFF)      m = 65535;
      else if (x[30:23] == 8'h00) m = 0;
      else begin
         rm = -$bitstoreal({x[31], 11'(int'(x[30:23]) - 127 + 1023), x[22:0], 29'b0}) * 256.0;
         if (rm >= 65535.0) m = 65535;
         else               m = $rtoi(rm);
      end
      y = m + m / 2 - m / 16;
      k = (y + 128) / 256;
      if (k > 255) k = 255;
      return k;
   endfunction

   // R5..R8: expected lane result
   function automatic logic [31:0] model_lane(int k, logic [31:0] d);
      int e;
      e = int'(d[30:23]);
      if (k == 0 || e == 255) return d;
      if (e <= k)             return {d[31], 31'b0};
      return {d[31], 8'(e - k), d[22:0]};
   endfunction

   task automatic send(logic [31:0] x, logic [VW-1:0] v, string tag);
      logic [VW-1:0] ev;
      int            k;
      k = model_k(x);
      for (int i = 0; i < LANES; i++) ev[i*32 +: 32] = model_lane(k, v[i*32 +: 32]);
      @(negedge clk);
      in_valid = 1'b1;
      in_x     = x;
      in_vec   = v;
      exp_q.push_back(ev);
      tag_q.push_back(tag);
      iss_q.push_back(cyc + 1);
   endtask

   task automatic idle(int n);
      @(negedge clk);
      in_valid = 1'b0;
      in_x     = '0;
      in_vec   = '0;
      repeat (n) @(negedge clk);
   endtask

   task automatic check_vec(string tag, logic [VW-1:0] act, logic [VW-1:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: out_vec=%h expected %h", tag, act, expv);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R1: out_valid=1 expected 0 (no pending input)");
         end else begin
            logic [VW-1:0] ev;
            string         tg;
            int            iss;
            ev  = exp_q.pop_front();
            tg  = tag_q.pop_front();
            iss = iss_q.pop_front();
            check_vec(tg, out_vec, ev);
            checks++;
            if (cyc - iss != 1) begin
               errors++;
               $display("FAIL R1: result edge offset=%0d expected 1", cyc - iss);
            end
         end
      end
   end

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL R1: watchdog expired, pending=%0d expected 0", exp_q.size());
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R9: out_valid=%b during reset expected 0", out_valid);
      end
      in_valid = 1'b1;   // held high while in reset: must not leak out
      repeat (2) @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R9: out_valid=%b after release expected 0", out_valid);
      end
      @(negedge clk);

      // back-to-back run (R1)
      send(32'hBF80_0000, {32'h3FC0_0000, 32'h4E80_0000, 32'hC040_0000, 32'h3F80_0000}, "R3 R5 x=-1");
      send(to_sp(-1.5),   {32'h3FC0_0000, 32'h4E80_0000, 32'hC040_0000, 32'h3F80_0000}, "R3 x=-1.5");
      send(to_sp(-10.0),  {32'h4000_0000, 32'h4E80_0000, 32'hC040_0000, 32'h3F80_0000}, "R3 x=-10");
      send(to_sp(-100.0), {32'h7FC0_0000, 32'h7F80_0000, 32'hBF80_0000, 32'h4E80_0000}, "R6 R7 x=-100");
      send(32'hFF80_0000, {32'h7F80_0000, 32'h4E80_0000, 32'hC040_0000, 32'h3F80_0000}, "R2 x=-inf");
      idle(3);

      send(32'h4040_0000, {32'h0000_0001, 32'h4E80_0000, 32'hC040_0000, 32'h3F80_0000}, "R4 x=+3");
      send(to_sp(-0.25),  {32'h0000_0001, 32'h8000_0000, 32'h4E80_0000, 32'h3F80_0000}, "R8 x=-0.25");
      send(32'h8000_0000, {32'h8000_0001, 32'h4000_0000, 32'hC040_0000, 32'h3F80_0000}, "R2 R8 x=-0");
      idle(2);

      send(to_sp(-200.0), {32'h7F80_0000, 32'h7F00_0000, 32'hFF7F_FFFF, 32'h4E80_0000}, "R3 x=-200 clip");
      send(32'h8000_0001, {32'h0000_0001, 32'h4E80_0000, 32'hC040_0000, 32'h3F80_0000}, "R2 subnormal x");
      send(to_sp(-(2.0 ** -100)), {32'h0000_0001, 32'h4E80_0000, 32'hC040_0000, 32'h3F80_0000}, "R2 tiny x");
      send(to_sp(-4.0),   {32'h0380_0000, 32'h0300_0000, 32'h8380_0000, 32'h8300_0000}, "R5 R6 x=-4 boundary");
      send(32'h7FC0_0000, {32'h0000_0001, 32'h8000_0000, 32'h4E80_0000, 32'h3F80_0000}, "R4 x=+NaN");
      idle(4);

      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R1: pending results=%0d expected 0", exp_q.size());
      end
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: out_valid=%b when idle expected 0", out_valid);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule